// File: doc/BRIEF.md
# Horizontal Sync Output Processor

This block turns a raw horizontal sync input into a clean sync output that lines up with the digitized pixel data. The raw sync may arrive with either polarity. The block works out which level is the active one by timing the high and low parts of each line. It then starts one pulse at the leading edge of every line. The pulse has a fixed width in pixel clocks, set by a configuration value, and is driven at a configured output level.

The pulse passes through a delay that matches the data path latency, so that downstream logic sees sync and pixel data on the same clock. A coast input, whose active level is also configurable, marks stretches where the incoming sync is not trustworthy, such as equalization pulses during vertical blanking. While coast is active, edges on the raw sync are discarded and pulses keep coming at the last line period that was measured.

All inputs are treated as asynchronous to the pixel clock and pass through a synchronizer first.

Top module: `hsync_out_proc`

## Requirements
- R1: While reset is asserted and right after it, `hs_out` sits at its inactive level (the inverse of `cfg_out_high`) and `pol_high` is 1.
- R2: At each rising edge of the synchronized sync, the block compares the high and low clock counts of the period that just ended. `pol_high` becomes 1 (active high) if the high count is no larger than the low count, and 0 (active low) otherwise. The first rising edge after reset or after coast only starts a measurement. While coast is active, `pol_high` does not change.
- R3: The active level of `hs_out` is 1 when `cfg_out_high` is 1, and 0 when `cfg_out_high` is 0.
- R4: A pulse starts on the leading edge of the detected active level: a rising edge when `pol_high` is 1, a falling edge when it is 0. The width of the input pulse has no effect on the output.
- R5: Each pulse lasts `cfg_width` clocks, with a value of 0 acting as 1. A new leading edge that arrives during a pulse restarts the full width.
- R6: With the default settings (two synchronizer stages, four-clock data latency), `hs_out` reaches its active level on the eighth rising clock edge. The count includes the edge that first samples the new sync level.
- R7: Coast is active when `coast_raw` equals `cfg_coast_high`. While coast is active, raw leading edges are ignored. Pulses are produced one measured line period apart, the first one a full period after the last accepted edge. The measured line period is the clock count between the last two accepted leading edges.
- R8: If no line period has been measured since reset, coast produces no pulses at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_raw | input | 1 | Raw horizontal sync, either polarity |
| coast_raw | input | 1 | Raw coast flag |
| cfg_coast_high | input | 1 | 1: coast active high, 0: coast active low |
| cfg_out_high | input | 1 | 1: output active high, 0: output active low |
| cfg_width | input | WIDTH_W (8) | Output pulse width in clocks, 0 acts as 1 |
| hs_out | output | 1 | Regenerated sync aligned to the data pipeline |
| pol_high | output | 1 | Detected input polarity, 1 when active high |

## Verification
A wrong polarity decision shows up as pulses that start on the trailing edge of the input, offset by the input pulse width, from the second full line onward. It also shows directly on `pol_high`. A fault in the line period or coast state only shows when coast is active: pulses drift off the expected cadence, appear during a coast that has no measured period, or follow the ignored mid-line pulses. A latency or width error shifts or stretches every output pulse relative to a reference computed from the input edges, and a cycle-exact comparison over whole lines catches it within one line.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
  // Level encoding shared by the polarity logic
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  localparam int DEF_PIPE_LAT    = 4;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/hsp_sync_stage.sv
`timescale 1ns/1ps
module hsp_sync_stage #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[0] <= din;
      for (int k = 1; k < STAGES; k++) q[k] <= q[k-1];
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/hsp_pol_detect.sv
`timescale 1ns/1ps
module hsp_pol_detect
  import hsp_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic freeze,
  output logic lead,
  output logic pol_high
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  level_e           pol_q;
  logic             lvl_d;
  logic             armed;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic             rise, fall;

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
  assign lead = (pol_q == LVL_HIGH) ? rise : fall;
  assign pol_high = (pol_q == LVL_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= LVL_HIGH;
      lvl_d  <= 1'b0;
      armed  <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      lvl_d <= lvl;
      if (freeze) begin
        armed  <= 1'b0;
        hi_cnt <= '0;
        lo_cnt <= '0;
      end else if (rise) begin
        if (armed) pol_q <= (hi_cnt <= lo_cnt) ? LVL_HIGH : LVL_LOW;
        armed  <= 1'b1;
        hi_cnt <= CNT_W'(1);
        lo_cnt <= '0;
      end else if (lvl) begin
        if (hi_cnt != CMAX) hi_cnt <= hi_cnt + CNT_W'(1);
      end else begin
        if (lo_cnt != CMAX) lo_cnt <= lo_cnt + CNT_W'(1);
      end
    end
  end

  // R2
  pol_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol_q) |-> $past(rise && !freeze));
endmodule

// File: rtl/hsp_line_timer.sv
`timescale 1ns/1ps
module hsp_line_timer #(
  parameter int PERIOD_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic lead,
  input  logic coast,
  output logic trig
);
  localparam logic [PERIOD_W-1:0] PMAX = '1;

  logic [PERIOD_W-1:0] ph;
  logic [PERIOD_W-1:0] len;
  logic                seen;
  logic [PERIOD_W:0]   ph_inc;
  logic                fly;

  assign ph_inc = {1'b0, ph} + (PERIOD_W+1)'(1);
  assign fly    = coast && (len != '0) && ({1'b0, len} == ph_inc);
  assign trig   = coast ? fly : lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      len  <= '0;
      seen <= 1'b0;
    end else begin
      if (trig) ph <= '0;
      else if (ph != PMAX) ph <= ph + PERIOD_W'(1);
      if (!coast && lead) begin
        seen <= 1'b1;
        if (seen) len <= ph_inc[PERIOD_W] ? PMAX : ph_inc[PERIOD_W-1:0];
      end
    end
  end

  // R8
  no_period_chk: assert property (@(posedge clk) disable iff (rst)
    (coast && !seen) |-> !trig);
endmodule

// File: rtl/hsp_pulse_gen.sv
`timescale 1ns/1ps
module hsp_pulse_gen #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic [WIDTH_W-1:0] cfg_width,
  output logic               active
);
  logic [WIDTH_W-1:0] cnt;
  logic [WIDTH_W-1:0] w_eff;

  assign w_eff  = (cfg_width == '0) ? WIDTH_W'(1) : cfg_width;
  assign active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (trig) cnt <= w_eff;
    else if (cnt != '0) cnt <= cnt - WIDTH_W'(1);
  end

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> active);
  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(trig));
endmodule

// File: rtl/hsp_delay_line.sv
`timescale 1ns/1ps
module hsp_delay_line #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic out_high,
  output logic dout
);
  logic [STAGES-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
      dout <= ~out_high;
    end else begin
      taps[0] <= din;
      for (int k = 1; k < STAGES; k++) taps[k] <= taps[k-1];
      dout <= out_high ? taps[STAGES-1] : ~taps[STAGES-1];
    end
  end
endmodule

// File: rtl/hsync_out_proc.sv
`timescale 1ns/1ps
module hsync_out_proc #(
  parameter int WIDTH_W     = 8,
  parameter int PERIOD_W    = 12,
  parameter int PIPE_LAT    = hsp_pkg::DEF_PIPE_LAT,
  parameter int SYNC_STAGES = hsp_pkg::DEF_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hs_raw,
  input  logic               coast_raw,
  input  logic               cfg_coast_high,
  input  logic               cfg_out_high,
  input  logic [WIDTH_W-1:0] cfg_width,
  output logic               hs_out,
  output logic               pol_high
);
  localparam int ALIGN = PIPE_LAT + 1;

  logic [1:0] raw_v, sync_v;
  logic       coast_act;
  logic       lead;
  logic       trig;
  logic       pulse_act;

  assign raw_v = {coast_raw, hs_raw};

  hsp_sync_stage #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw_v), .dout(sync_v));

  assign coast_act = cfg_coast_high ? sync_v[1] : ~sync_v[1];

  hsp_pol_detect #(.CNT_W(PERIOD_W)) u_pol (
    .clk(clk), .rst(rst), .lvl(sync_v[0]), .freeze(coast_act),
    .lead(lead), .pol_high(pol_high));

  hsp_line_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .lead(lead), .coast(coast_act), .trig(trig));

  hsp_pulse_gen #(.WIDTH_W(WIDTH_W)) u_pulse (
    .clk(clk), .rst(rst), .trig(trig), .cfg_width(cfg_width),
    .active(pulse_act));

  hsp_delay_line #(.STAGES(PIPE_LAT)) u_dly (
    .clk(clk), .rst(rst), .din(pulse_act), .out_high(cfg_out_high),
    .dout(hs_out));

  // R6
  align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_act) |-> ##ALIGN (hs_out == cfg_out_high));
endmodule

// File: tb/hsync_out_proc_test.sv
`timescale 1ns/1ps
module hsync_out_proc_test;
  localparam int N   = 600;
  localparam int LAT = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hs_raw = 1'b0;
  logic       coast_raw = 1'b0;
  logic       cfg_coast_high = 1'b1;
  logic       cfg_out_high = 1'b1;
  logic [7:0] cfg_width = 8'd4;
  logic       hs_out;
  logic       pol_high;

  logic s_st [N];
  logic c_st [N];
  logic obs  [N];
  logic expv [N];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #2 clk = ~clk;

  hsync_out_proc uut (
    .clk(clk), .rst(rst), .hs_raw(hs_raw), .coast_raw(coast_raw),
    .cfg_coast_high(cfg_coast_high), .cfg_out_high(cfg_out_high),
    .cfg_width(cfg_width), .hs_out(hs_out), .pol_high(pol_high));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit cpol, input bit opol, input int w, input bit cidle);
    @(negedge clk);
    rst = 1'b1;
    cfg_coast_high = cpol;
    cfg_out_high = opol;
    cfg_width = 8'(w);
    hs_raw = 1'b0;
    coast_raw = cidle;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_stim(input bit s_idle, input bit c_idle);
    for (int i = 0; i < N; i++) begin
      s_st[i] = s_idle;
      c_st[i] = c_idle;
    end
  endtask

  task automatic fill_lines(input int start, input int nl, input int per,
                            input int act_len, input bit act_high);
    for (int l = 0; l < nl; l++)
      for (int k = 0; k < per; k++)
        if (start + l*per + k < N)
          s_st[start + l*per + k] = (k < act_len) ? act_high : !act_high;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      obs[i] = hs_out;
      hs_raw = s_st[i];
      coast_raw = c_st[i];
    end
  endtask

  // Reference built from the requirements: leading edges, coast cadence, width, latency
  task automatic build_exp(input int n, input bit pol, input bit cpol,
                           input int w, input bit opol);
    bit trig [N];
    int last = -1;
    int len = 0;
    bit seen = 0;
    int weff = (w == 0) ? 1 : w;
    int lastt = -1;
    for (int i = 0; i < N; i++) trig[i] = 0;
    for (int i = 1; i < n; i++) begin
      bit a  = pol ? s_st[i]   : !s_st[i];
      bit ap = pol ? s_st[i-1] : !s_st[i-1];
      bit co = cpol ? c_st[i] : !c_st[i];
      bit t  = 0;
      if (co) begin
        if (len != 0 && last >= 0 && (i - last) == len) t = 1;
      end else if (a && !ap) begin
        t = 1;
        if (seen) len = i - last;
        seen = 1;
      end
      if (t) begin
        last = i;
        trig[i] = 1;
      end
    end
    for (int j = 0; j < n; j++) begin
      bit act;
      if (j >= LAT && trig[j-LAT]) lastt = j - LAT;
      act = (lastt >= 0) && ((j - LAT - lastt) < weff);
      expv[j] = act ? opol : !opol;
    end
  endtask

  task automatic cmp_window(input int from, input int upto, input string req);
    int bad = 0;
    int first = -1;
    for (int j = from; j <= upto; j++)
      if (obs[j] !== expv[j]) begin
        bad++;
        if (first < 0) first = j;
      end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " window mismatch at first bad cycle"}, int'(obs[first]), int'(expv[first]));
  endtask

  // R1, R3: reset state for both output polarities
  task automatic t_reset();
    do_reset(1'b1, 1'b1, 4, 1'b0);
    rst = 1'b1;
    chk(hs_out == 1'b0, "R1 idle level, active-high output", hs_out, 0);
    chk(pol_high == 1'b1, "R1 polarity status after reset", pol_high, 1);
    do_reset(1'b1, 1'b0, 4, 1'b0);
    chk(hs_out == 1'b1, "R1 R3 idle level, active-low output", hs_out, 1);
  endtask

  // R2 R4 R5 R6: active-high input, pulse width 6
  task automatic t_high_input();
    clear_stim(1'b0, 1'b0);
    fill_lines(5, 12, 40, 4, 1'b1);
    do_reset(1'b1, 1'b1, 6, 1'b0);
    run(500);
    build_exp(500, 1'b1, 1'b1, 6, 1'b1);
    cmp_window(200, 499, "R4");
    chk(pol_high == 1'b1, "R2 active-high input detected", pol_high, 1);
    chk(obs[252] == 1'b0, "R6 output still idle one cycle early", obs[252], 0);
    chk(obs[253] == 1'b1, "R6 output active at eighth edge", obs[253], 1);
    chk(obs[258] == 1'b1, "R5 last cycle of width 6", obs[258], 1);
    chk(obs[259] == 1'b0, "R5 pulse ends after width 6", obs[259], 0);
  endtask

  // R2 R3 R4: active-low input, active-low output
  task automatic t_low_input();
    clear_stim(1'b1, 1'b0);
    fill_lines(5, 12, 40, 4, 1'b0);
    do_reset(1'b1, 1'b0, 3, 1'b0);
    run(500);
    build_exp(500, 1'b0, 1'b1, 3, 1'b0);
    cmp_window(200, 499, "R4 falling leading edge");
    chk(pol_high == 1'b0, "R2 active-low input detected", pol_high, 0);
    chk(obs[253] == 1'b0, "R3 active-low output level", obs[253], 0);
    chk(obs[252] == 1'b1, "R3 active-low idle level", obs[252], 1);
  endtask

  // R5: zero width acts as one, wide input pulse does not widen output
  task automatic t_zero_width();
    clear_stim(1'b0, 1'b0);
    fill_lines(5, 15, 30, 10, 1'b1);
    do_reset(1'b1, 1'b1, 0, 1'b0);
    run(470);
    build_exp(470, 1'b1, 1'b1, 0, 1'b1);
    cmp_window(150, 469, "R5");
    chk(obs[253] == 1'b1, "R5 zero width gives one active cycle", obs[253], 1);
    chk(obs[254] == 1'b0, "R5 zero width pulse ends after one cycle", obs[254], 0);
  endtask

  // R7: flywheel pulses during coast, mid-line pulses ignored
  task automatic t_coast();
    clear_stim(1'b0, 1'b0);
    fill_lines(5, 10, 50, 5, 1'b1);
    for (int i = 280; i <= 430; i++) begin
      int k = (i - 5) % 50;
      c_st[i] = 1'b1;
      s_st[i] = (k >= 20 && k <= 22);
    end
    do_reset(1'b1, 1'b1, 4, 1'b0);
    run(520);
    build_exp(520, 1'b1, 1'b1, 4, 1'b1);
    cmp_window(200, 519, "R7");
    chk(obs[313] == 1'b1, "R7 pulse one period after last accepted edge", obs[313], 1);
    chk(obs[333] == 1'b0, "R7 sync edge during coast ignored", obs[333], 0);
    chk(pol_high == 1'b1, "R2 polarity held through coast", pol_high, 1);
  endtask

  // R8 R2: coast active low from reset, no period known
  task automatic t_coast_no_period();
    clear_stim(1'b1, 1'b0);
    fill_lines(5, 7, 40, 4, 1'b0);
    do_reset(1'b0, 1'b1, 5, 1'b0);
    run(300);
    build_exp(300, 1'b0, 1'b0, 5, 1'b1);
    cmp_window(0, 299, "R8 no pulses without measured period");
    chk(pol_high == 1'b1, "R2 no polarity update while coasting", pol_high, 1);
  endtask

  // R5: retrigger restarts width, output stays active
  task automatic t_retrigger();
    clear_stim(1'b0, 1'b0);
    fill_lines(5, 25, 12, 3, 1'b1);
    do_reset(1'b1, 1'b1, 20, 1'b0);
    run(300);
    build_exp(300, 1'b1, 1'b1, 20, 1'b1);
    cmp_window(100, 299, "R5 restart during pulse");
  endtask

  initial begin
    t_reset();
    t_high_input();
    t_low_input();
    t_zero_width();
    t_coast();
    t_coast_no_period();
    t_retrigger();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule